// File: doc/BRIEF.md
# Multichannel PWM with Period-Aligned Duty Buffering

This block drives a bank of pulse-width-modulated outputs from one free-running timebase. The timebase counts from zero up to a programmable terminal count and then starts again; that restart marks the boundary of every period. Each channel holds two duty values, a rise point and a fall point. The output is high while the timebase lies between them.

Channels chosen at synthesis carry a second, buffered copy of both duty values. One register bit, written over an APB slave port, selects the update mode for all buffered channels. When the bit is set, software writes go into the buffer, and every buffered channel moves its buffer into the active compare at the same period boundary. When the bit is clear, writes reach the comparator at once. Channels built without buffers always update at once.

A second synthesis mask turns chosen channels into a first-order pulse-density converter. Such a channel adds its fall value to an accumulator on every clock and drives the carry-out as its output, so its average high fraction is fall/2^DW.

Top module: `pwm_bank`

## Requirements
- R1: After reset the period, the sync-mode bit, every duty value and every DAC accumulator are zero, and all `pwm_o` bits are low.
- R2: The timebase advances by one per clock and returns to 0 on the clock after it reaches or exceeds the period register (byte 0x00, bits DW-1:0). A period of P gives a cycle of P+1 clocks.
- R3: A PWM channel's output, registered one clock after the timebase value it reflects, is high when rise <= count < fall. When rise equals fall, or rise exceeds fall, it stays low.
- R4: The sync bit is bit 0 at byte 0x04. While it is 1, the active duty values of a buffered channel change only in the clock where the timebase wraps. All buffered channels load together in that clock.
- R5: A duty write whose APB access phase falls in the wrap clock is included in that clock's buffered load.
- R6: A write reaches the active compare on the next clock in two cases: on an unbuffered channel at any time, and on a buffered channel while the sync bit is 0.
- R7: On a DAC channel the output is the carry of accumulator + fall value, taken each clock. Over any 2^DW consecutive clocks with a constant fall value F, the output is high for exactly F clocks.
- R8: Channel c has its rise value at byte 0x10 + 8c and its fall value at byte 0x14 + 8c, both in bits DW-1:0. A read returns the last value written there. Period and sync read back what was written. Every other address reads as zero. `pready` is always 1, so there are no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pwm_o | output | NCH | Channel outputs |

## Verification
The case that needs care is a software write to a duty register landing in the same clock as the timebase wrap. In that clock the buffered load and the register write both act on one channel. The bench waits until its model timebase sits one count before the terminal value and then starts an APB write, so the access phase lands on the wrap. A directed sample later in that period must show the newly written fall point and not the earlier one. Every clock, the behavioural model predicts all outputs, and the bench compares them against the design.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_PERIOD,
    KIND_SYNC,
    KIND_DUTY
  } reg_kind_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 8,
  parameter int AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [AW-1:0]            paddr,
  input  logic [31:0]              pwdata,
  output logic [31:0]              prdata,
  output logic [DW-1:0]            period_o,
  output logic                     sync_o,
  output logic [NCH-1:0]           wr_rise_o,
  output logic [NCH-1:0]           wr_fall_o,
  output logic [DW-1:0]            wdata_o,
  input  logic [NCH-1:0][DW-1:0]   rb_rise_i,
  input  logic [NCH-1:0][DW-1:0]   rb_fall_i
);
  localparam int IW = AW - 2;
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IW-1:0] IDX_PERIOD = IW'(0);
  localparam logic [IW-1:0] IDX_SYNC   = IW'(1);
  localparam logic [IW-1:0] DUTY_LO    = IW'(4);
  localparam logic [IW-1:0] DUTY_HI    = IW'(4 + 2 * NCH);

  logic [IW-1:0] idx;
  logic [IW-1:0] off;
  logic [CW-1:0] ch_sel;
  logic          fld_fall;
  reg_kind_e     kind;
  logic          wr_en;
  logic [DW-1:0] period_q, period_d;
  logic          sync_q, sync_d;
  logic          unused_bits;

  assign idx         = paddr[AW-1:2];
  assign wr_en       = psel & penable & pwrite;
  assign wdata_o     = pwdata[DW-1:0];
  assign unused_bits = ^{pwdata[31:DW], paddr[1:0]};

  always_comb begin
    kind     = KIND_NONE;
    off      = '0;
    ch_sel   = '0;
    fld_fall = 1'b0;
    if (idx == IDX_PERIOD) begin
      kind = KIND_PERIOD;
    end else if (idx == IDX_SYNC) begin
      kind = KIND_SYNC;
    end else if (idx >= DUTY_LO && idx < DUTY_HI) begin
      kind     = KIND_DUTY;
      off      = idx - DUTY_LO;
      ch_sel   = CW'(off[IW-1:1]);
      fld_fall = off[0];
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wr_rise_o[i] = wr_en && (kind == KIND_DUTY) && (ch_sel == CW'(i)) && !fld_fall;
      wr_fall_o[i] = wr_en && (kind == KIND_DUTY) && (ch_sel == CW'(i)) && fld_fall;
    end
  end

  always_comb begin
    period_d = period_q;
    sync_d   = sync_q;
    if (wr_en && kind == KIND_PERIOD) period_d = pwdata[DW-1:0];
    if (wr_en && kind == KIND_SYNC)   sync_d   = pwdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      sync_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      sync_q   <= sync_d;
    end
  end

  always_comb begin
    unique case (kind)
      KIND_PERIOD: prdata = 32'(period_q);
      KIND_SYNC:   prdata = 32'(sync_q);
      KIND_DUTY:   prdata = fld_fall ? 32'(rb_fall_i[ch_sel]) : 32'(rb_rise_i[ch_sel]);
      default:     prdata = '0;
    endcase
  end

  assign period_o = period_q;
  assign sync_o   = sync_q;

  p_period_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == KIND_PERIOD) |=> (period_o == $past(pwdata[DW-1:0])));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_rise_o, wr_fall_o}));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] period_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign wrap_o = (cnt_q >= period_i);

  always_comb begin
    cnt_d = wrap_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int   DW       = 8,
  parameter logic BUFFERED = 1'b0,
  parameter logic DAC      = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          sync_i,
  input  logic          wr_rise_i,
  input  logic          wr_fall_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rb_rise_o,
  output logic [DW-1:0] rb_fall_o,
  output logic          out_o
);
  logic [DW-1:0] act_rise_q, act_rise_d;
  logic [DW-1:0] act_fall_q, act_fall_d;
  logic          out_q, out_d;

  // Duty storage: buffered or direct
  if (BUFFERED) begin : g_buf
    logic [DW-1:0] stg_rise_q, stg_rise_d;
    logic [DW-1:0] stg_fall_q, stg_fall_d;

    always_comb begin
      stg_rise_d = wr_rise_i ? wdata_i : stg_rise_q;
      stg_fall_d = wr_fall_i ? wdata_i : stg_fall_q;
      act_rise_d = act_rise_q;
      act_fall_d = act_fall_q;
      if (sync_i) begin
        if (wrap_i) begin
          act_rise_d = stg_rise_d;
          act_fall_d = stg_fall_d;
        end
      end else begin
        if (wr_rise_i) act_rise_d = wdata_i;
        if (wr_fall_i) act_fall_d = wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_rise_q <= '0;
        stg_fall_q <= '0;
      end else begin
        stg_rise_q <= stg_rise_d;
        stg_fall_q <= stg_fall_d;
      end
    end

    assign rb_rise_o = stg_rise_q;
    assign rb_fall_o = stg_fall_q;

    p_hold_until_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && !wrap_i) |=> ($stable(act_rise_q) && $stable(act_fall_q)));

    p_async_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && wr_fall_i) |=> (act_fall_q == $past(wdata_i)));
  end else begin : g_direct
    always_comb begin
      act_rise_d = wr_rise_i ? wdata_i : act_rise_q;
      act_fall_d = wr_fall_i ? wdata_i : act_fall_q;
    end

    assign rb_rise_o = act_rise_q;
    assign rb_fall_o = act_fall_q;

    p_async_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise_i |=> (act_rise_q == $past(wdata_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_rise_q <= '0;
      act_fall_q <= '0;
    end else begin
      act_rise_q <= act_rise_d;
      act_fall_q <= act_fall_d;
    end
  end

  // Output generator: comparator or pulse-density accumulator
  if (DAC) begin : g_dac
    logic [DW-1:0] acc_q, acc_d;
    logic [DW:0]   sum;
    logic          unused_dac;

    assign unused_dac = ^{cnt_i, act_rise_q};

    always_comb begin
      sum   = {1'b0, acc_q} + {1'b0, act_fall_q};
      acc_d = sum[DW-1:0];
      out_d = sum[DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end

    p_dac_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_fall_q == '0) |=> !out_o);
  end else begin : g_pwm
    always_comb begin
      out_d = (cnt_i >= act_rise_q) && (cnt_i < act_fall_q);
    end

    p_equal_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_rise_q >= act_fall_q) |=> !out_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int             NCH      = 16,
  parameter int             DW       = 8,
  parameter int             AW       = 8,
  parameter logic [NCH-1:0] BUF_MASK = 16'h00FF,
  parameter logic [NCH-1:0] DAC_MASK = 16'hC000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [AW-1:0]  paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           pready,
  output logic [NCH-1:0] pwm_o
);
  logic [DW-1:0]          period;
  logic                   sync_en;
  logic [NCH-1:0]         wr_rise;
  logic [NCH-1:0]         wr_fall;
  logic [DW-1:0]          wdata;
  logic [NCH-1:0][DW-1:0] rb_rise;
  logic [NCH-1:0][DW-1:0] rb_fall;
  logic [DW-1:0]          cnt;
  logic                   wrap;

  assign pready = 1'b1;

  pwm_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .period_o  (period),
    .sync_o    (sync_en),
    .wr_rise_o (wr_rise),
    .wr_fall_o (wr_fall),
    .wdata_o   (wdata),
    .rb_rise_i (rb_rise),
    .rb_fall_i (rb_fall)
  );

  pwm_timebase #(.DW(DW)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_chan #(
      .DW       (DW),
      .BUFFERED (BUF_MASK[c]),
      .DAC      (DAC_MASK[c])
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt),
      .wrap_i    (wrap),
      .sync_i    (sync_en),
      .wr_rise_i (wr_rise[c]),
      .wr_fall_i (wr_fall[c]),
      .wdata_i   (wdata),
      .rb_rise_o (rb_rise[c]),
      .rb_fall_o (rb_fall[c]),
      .out_o     (pwm_o[c])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pwm_o == '0));
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam logic [15:0] BUFM = 16'h00FF;
  localparam logic [15:0] DACM = 16'hC000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [15:0] pwm_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit cmp_on = 1'b0;

  // model state
  int m_cnt, m_period, m_sync;
  int stg_r[NCH], stg_f[NCH], act_r[NCH], act_f[NCH], acc[NCH], lw_r[NCH], lw_f[NCH];
  logic [15:0] m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank #(.NCH(16), .DW(8), .AW(8), .BUF_MASK(BUFM), .DAC_MASK(DACM)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pwm_o(pwm_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_period = 0; m_sync = 0; m_out = '0;
      for (int c = 0; c < NCH; c++) begin
        stg_r[c] = 0; stg_f[c] = 0; act_r[c] = 0; act_f[c] = 0; acc[c] = 0; lw_r[c] = 0; lw_f[c] = 0;
      end
    end else begin
      logic [15:0] n_out;
      bit wr, wrap;
      int widx, dat, s;
      wr = psel && penable && pwrite;
      widx = int'(paddr) / 4;
      dat = int'(pwdata & 32'hFF);
      for (int c = 0; c < NCH; c++) begin
        if (DACM[c]) begin
          s = acc[c] + act_f[c];
          n_out[c] = (s >= 256);
          acc[c] = s % 256;
        end else begin
          n_out[c] = (m_cnt >= act_r[c]) && (m_cnt < act_f[c]);
        end
      end
      wrap = (m_cnt >= m_period);
      for (int c = 0; c < NCH; c++) begin
        bit wr_r, wr_f;
        wr_r = wr && (widx == 4 + 2*c);
        wr_f = wr && (widx == 5 + 2*c);
        if (wr_r) lw_r[c] = dat;
        if (wr_f) lw_f[c] = dat;
        if (BUFM[c]) begin
          if (wr_r) stg_r[c] = dat;
          if (wr_f) stg_f[c] = dat;
          if (m_sync != 0) begin
            if (wrap) begin act_r[c] = stg_r[c]; act_f[c] = stg_f[c]; end
          end else begin
            if (wr_r) act_r[c] = dat;
            if (wr_f) act_f[c] = dat;
          end
        end else begin
          if (wr_r) act_r[c] = dat;
          if (wr_f) act_f[c] = dat;
        end
      end
      m_cnt = wrap ? 0 : m_cnt + 1;
      if (wr && widx == 0) m_period = dat;
      if (wr && widx == 1) m_sync = int'(pwdata & 32'h1);
      m_out = n_out;
    end
  end

  function automatic int model_read(int addr);
    int w = addr / 4;
    if (w == 0) return m_period;
    if (w == 1) return m_sync;
    if (w >= 4 && w < 4 + 2*NCH) return ((w - 4) % 2 == 0) ? lw_r[(w-4)/2] : lw_f[(w-4)/2];
    return 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag, "pwm outputs", int'(pwm_o & ~DACM), int'(m_out & ~DACM));
      check("R7", "dac outputs", int'(pwm_o & DACM), int'(m_out & DACM));
    end
  end

  task automatic apb_write(int addr, int data);
    paddr = 8'(addr); pwdata = 32'(data); pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(string req, int addr);
    paddr = 8'(addr); pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    check(req, $sformatf("read 0x%02h", addr), int'(prdata), model_read(addr));
    check(req, "pready", int'(pready), 1);
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ones;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1", "outputs after reset", int'(pwm_o), 0);
    cmp_on = 1'b1;
    apb_read("R1", 'h00);
    apb_read("R1", 'h04);
    apb_read("R1", 'h10);
    apb_read("R1", 'h7C);

    tag = "R2";
    apb_write('h00, 9);
    apb_write('h10 + 8*8, 0);
    apb_write('h14 + 8*8, 1);
    idle(30);

    tag = "R3";
    apb_write('h10 + 8*9, 3);  apb_write('h14 + 8*9, 7);
    apb_write('h10 + 8*10, 5); apb_write('h14 + 8*10, 5);
    apb_write('h10 + 8*11, 7); apb_write('h14 + 8*11, 3);
    idle(25);

    tag = "R6";
    apb_write('h10, 1); apb_write('h14, 4);
    apb_write('h10 + 8*12, 2); apb_write('h14 + 8*12, 6);
    idle(20);

    tag = "R4";
    apb_write('h04, 1);
    while (m_cnt != 3) @(negedge clk);
    apb_write('h10 + 8*1, 2); apb_write('h14 + 8*1, 8);
    apb_write('h10 + 8*2, 0); apb_write('h14 + 8*2, 9);
    apb_write('h14 + 8*12, 9);
    idle(30);

    tag = "R5";
    while (m_cnt != 8) @(negedge clk);
    apb_write('h14 + 8*1, 3);
    while (m_cnt != 5) @(negedge clk);
    check("R5", "ch1 after boundary-cycle write", int'(pwm_o[1]), 0);
    idle(20);

    tag = "R7";
    apb_write('h14 + 8*14, 64);
    apb_write('h14 + 8*15, 200);
    idle(5);
    ones = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_o[14]) ones++;
    end
    check("R7", "ch14 density over 256 clocks", ones, 64);
    idle(10);

    tag = "R8";
    apb_write('h04, 0);
    apb_read("R8", 'h00);
    apb_read("R8", 'h04);
    apb_read("R8", 'h14 + 8*1);
    apb_read("R8", 'h10 + 8*9);
    apb_read("R8", 'h14 + 8*15);
    apb_read("R8", 'h0C);
    apb_read("R8", 'h90);
    apb_read("R8", 'hFC);
    idle(5);

    cmp_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule